// File: doc/BRIEF.md
# Balance Command CRC Validator

This block sits behind the serial front end of a six-channel bidirectional cell balancer. Each completed write delivers a 16-bit word: a 12-bit message, two control bits per channel, then a 4-bit check field. The block checks the word against a CRC-4 code. The check bits travel inverted, so an all-zero word never passes. A word that passes is loaded into a holding register. A word that fails empties the holding register instead.

A separate execute strobe copies the holding register into the active command register, which drives the six channel controllers. A failed write therefore leaves the running command alone, but an execute that follows it turns every channel off.

A mode input selects single-transformer operation. In that mode only one channel may run at a time. A write that asks for two or more active channels is refused. An execute whose held command has two or more active channels clears the active register. A status output tells whether the last write was accepted.

Top module: `bal_cmd_validator`

## Requirements
- R1: Word layout: bits [15:4] carry the message and bits [3:0] carry the inverted check field. Channel n (n = 1..6) sits at word bits [17-2n:16-2n], so channel 1 is bits [15:14] and channel 6 is bits [5:4]. The hold and active outputs keep the same order, with channel 1 at [11:10]. Pair codes: 00 idle, 01 nonsynchronous discharge, 10 synchronous discharge, 11 charge. A channel is active when its pair is nonzero.
- R2: A word passes its check only when the 16-bit value {word[15:4], ~word[3:0]} is divisible by x^4 + x + 1 over GF(2), so the all-zero word fails.
- R3: On the clock edge where the write strobe is high and the word is accepted, the holding register takes word[15:4] and the status output goes to 1.
- R4: On the clock edge where the write strobe is high and the word is rejected, the holding register becomes all zero and the status output goes to 0.
- R5: While the write strobe is low, the holding register and the status output keep their values.
- R6: On the clock edge where the execute strobe is high, the active register takes the holding register's value from before that edge. While the execute strobe is low, the active register does not change, even when a write is rejected.
- R7: While the single-channel mode input is 1, a word that passes its check but has more than one active channel is rejected exactly as in R4.
- R8: While the single-channel mode input is 1 at an execute, a held command with more than one active channel makes the active register all idle.
- R9: Reset is asynchronous and active low, and its release is synchronised inside the block. In reset, the holding register, the active register and the status output are all zero.
- R10: When a write and an execute fall on the same edge, the active register takes the older held value and the holding register takes the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write-complete strobe, one cycle per word |
| wr_word | input | 16 | Received write word (message and inverted check bits) |
| exec_stb | input | 1 | Execute strobe |
| single_mode | input | 1 | Single-channel (one transformer) operation |
| hold_cmd | output | 12 | Command holding register |
| act_cmd | output | 12 | Active command driving the channel controllers |
| wr_ok | output | 1 | Last write accepted |

## Verification
The bench aims at words that are one bit away from valid. A design that left the check bits uninverted, used the wrong polynomial, or skipped the bottom stage would accept those words or reject their valid neighbours. It checks that an execute after a rejected write turns all channels off, and that the rejected write itself leaves the active register alone. A design that gated the write path into the active register, or forgot to clear the holding register, would fail one of those two checks. Two-channel commands are tried with single-channel mode on at the write and, separately, only at the execute. A same-edge write and execute checks that the active register takes the older held value rather than the word just written.

// File: rtl/bcv_pkg.sv
package bcv_pkg;
  localparam int unsigned CH_COUNT  = 6;
  localparam int unsigned PAIR_BITS = 2;
  localparam int unsigned CHK_BITS  = 4;
  localparam logic [3:0]  CHK_POLY  = 4'b0011;  // x^4 + x + 1, x^4 implied

  typedef enum logic [1:0] {
    CH_IDLE      = 2'b00,
    CH_DIS_ASYNC = 2'b01,
    CH_DIS_SYNC  = 2'b10,
    CH_CHARGE    = 2'b11
  } ch_mode_e;
endpackage

// File: rtl/bcv_crc_chk.sv
module bcv_crc_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CRC_W  = 4,
  parameter logic [CRC_W-1:0] POLY = 4'b0011
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              pass_o
);
  localparam int unsigned MSG_W = DATA_W - CRC_W;

  logic [DATA_W-1:0] dividend;
  logic [CRC_W-1:0]  rem [0:DATA_W];

  // check field arrives inverted
  assign dividend = {data_i[DATA_W-1:CRC_W], ~data_i[CRC_W-1:0]};
  assign rem[0]   = '0;

  // one shift stage per bit, MSB first
  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    logic fb;
    assign fb         = dividend[DATA_W-1-i] ^ rem[i][CRC_W-1];
    assign rem[i+1]   = {rem[i][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
  end

  assign pass_o = (rem[DATA_W] == '0) && (MSG_W > 0);
endmodule

// File: rtl/bcv_multi_detect.sv
module bcv_multi_detect #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned PAIR_W = 2
) (
  input  logic [NUM_CH*PAIR_W-1:0] cmd_i,
  output logic                     multi_o
);
  logic [NUM_CH-1:0] busy;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign busy[c] = |cmd_i[c*PAIR_W +: PAIR_W];
  end

  assign multi_o = ($countones(busy) > 1);
endmodule

// File: rtl/bcv_cmd_store.sv
module bcv_cmd_store #(
  parameter int unsigned MSG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb_i,
  input  logic             wr_accept_i,
  input  logic [MSG_W-1:0] wr_msg_i,
  input  logic             exec_stb_i,
  input  logic             exec_block_i,
  output logic [MSG_W-1:0] hold_o,
  output logic [MSG_W-1:0] act_o,
  output logic             ok_o
);
  logic [MSG_W-1:0] hold_q, hold_d;
  logic [MSG_W-1:0] act_q, act_d;
  logic             ok_q, ok_d;
  logic             hold_en, act_en;

  assign hold_en = wr_stb_i;
  assign act_en  = exec_stb_i;

  always_comb begin
    hold_d = wr_accept_i ? wr_msg_i : '0;
    ok_d   = wr_accept_i;
    act_d  = exec_block_i ? '0 : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ok_q   <= 1'b0;
    end else if (hold_en) begin
      hold_q <= hold_d;
      ok_q   <= ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  assign hold_o = hold_q;
  assign act_o  = act_q;
  assign ok_o   = ok_q;
endmodule

// File: rtl/bal_cmd_validator.sv
module bal_cmd_validator #(
  parameter int unsigned NUM_CH = bcv_pkg::CH_COUNT,
  parameter int unsigned PAIR_W = bcv_pkg::PAIR_BITS,
  parameter int unsigned CRC_W  = bcv_pkg::CHK_BITS,
  parameter logic [CRC_W-1:0] POLY = bcv_pkg::CHK_POLY,
  localparam int unsigned MSG_W  = NUM_CH * PAIR_W,
  localparam int unsigned WORD_W = MSG_W + CRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              exec_stb,
  input  logic              single_mode,
  output logic [MSG_W-1:0]  hold_cmd,
  output logic [MSG_W-1:0]  act_cmd,
  output logic              wr_ok
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [MSG_W-1:0] msg;
  logic             crc_pass;
  logic             msg_multi;
  logic             hold_multi;
  logic             accept;
  logic             exec_block;

  // asynchronous assert, synchronised release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign msg = wr_word[WORD_W-1:CRC_W];

  bcv_crc_chk #(.DATA_W(WORD_W), .CRC_W(CRC_W), .POLY(POLY)) u_crc (
    .data_i (wr_word),
    .pass_o (crc_pass)
  );

  bcv_multi_detect #(.NUM_CH(NUM_CH), .PAIR_W(PAIR_W)) u_msg_multi (
    .cmd_i   (msg),
    .multi_o (msg_multi)
  );

  bcv_multi_detect #(.NUM_CH(NUM_CH), .PAIR_W(PAIR_W)) u_hold_multi (
    .cmd_i   (hold_cmd),
    .multi_o (hold_multi)
  );

  assign accept     = crc_pass && !(single_mode && msg_multi);
  assign exec_block = single_mode && hold_multi;

  bcv_cmd_store #(.MSG_W(MSG_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .wr_stb_i     (wr_stb),
    .wr_accept_i  (accept),
    .wr_msg_i     (msg),
    .exec_stb_i   (exec_stb),
    .exec_block_i (exec_block),
    .hold_o       (hold_cmd),
    .act_o        (act_cmd),
    .ok_o         (wr_ok)
  );
endmodule

// File: rtl/bcv_checker.sv
module bcv_checker #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned PAIR_W = 2,
  parameter int unsigned CRC_W  = 4,
  localparam int unsigned MSG_W  = NUM_CH * PAIR_W,
  localparam int unsigned WORD_W = MSG_W + CRC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [WORD_W-1:0] wr_word,
  input logic              exec_stb,
  input logic              single_mode,
  input logic [MSG_W-1:0]  hold_cmd,
  input logic [MSG_W-1:0]  act_cmd,
  input logic              wr_ok
);
  logic [NUM_CH-1:0] act_busy, hold_busy;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_busy
    assign act_busy[c]  = |act_cmd[c*PAIR_W +: PAIR_W];
    assign hold_busy[c] = |hold_cmd[c*PAIR_W +: PAIR_W];
  end

  // R2: the all-zero word never passes
  a_r2_zero_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_word == '0) |=> !wr_ok);

  a_r3_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (!wr_ok || hold_cmd == $past(wr_word[WORD_W-1:CRC_W])));

  a_r4_reject_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (wr_ok || hold_cmd == '0));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(hold_cmd) && $stable(wr_ok)));

  a_r6_act_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_stb |=> $stable(act_cmd));

  a_r6_exec_copies: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |=> (act_cmd == $past(hold_cmd) || act_cmd == '0));

  a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && single_mode) |=> ($countones(hold_busy) <= 1));

  a_r8_single_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && single_mode) |=> ($countones(act_busy) <= 1));
endmodule

bind bal_cmd_validator bcv_checker #(
  .NUM_CH (NUM_CH),
  .PAIR_W (PAIR_W),
  .CRC_W  (CRC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_stb      (wr_stb),
  .wr_word     (wr_word),
  .exec_stb    (exec_stb),
  .single_mode (single_mode),
  .hold_cmd    (hold_cmd),
  .act_cmd     (act_cmd),
  .wr_ok       (wr_ok)
);

// File: tb/bal_cmd_validator_tb_top.sv
module bal_cmd_validator_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb, exec_stb, single_mode;
  logic [15:0] wr_word;
  logic [11:0] hold_cmd, act_cmd;
  logic        wr_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [11:0] exp_hold, exp_act;
  logic        exp_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  bal_cmd_validator dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_word(wr_word),
    .exec_stb(exec_stb), .single_mode(single_mode),
    .hold_cmd(hold_cmd), .act_cmd(act_cmd), .wr_ok(wr_ok)
  );

  // polynomial long division of {msg, ~chk} by 10011b
  function automatic logic [3:0] ref_rem(input logic [15:0] w);
    logic [15:0] d;
    d = {w[15:4], ~w[3:0]};
    for (int i = 15; i >= 4; i--)
      if (d[i]) d = d ^ (16'b10011 << (i - 4));
    return d[3:0];
  endfunction

  function automatic int ref_busy(input logic [11:0] m);
    int n = 0;
    for (int c = 0; c < 6; c++) if (m[2*c +: 2] != 2'b00) n++;
    return n;
  endfunction

  function automatic logic [15:0] make_valid(input logic [11:0] m);
    for (int c = 0; c < 16; c++)
      if (ref_rem({m, c[3:0]}) == 4'd0) return {m, c[3:0]};
    return {m, 4'h0};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive one cycle, update model, check after the edge
  task automatic step(input string tag, input logic w, input logic [15:0] word,
                      input logic e, input logic s);
    logic        ok_n;
    logic [11:0] hold_n, act_n;
    @(negedge clk);
    wr_stb = w; wr_word = word; exec_stb = e; single_mode = s;
    hold_n = exp_hold; act_n = exp_act; ok_n = exp_ok;
    if (e) act_n = (s && ref_busy(exp_hold) > 1) ? 12'h000 : exp_hold;
    if (w) begin
      ok_n   = (ref_rem(word) == 4'd0) && !(s && ref_busy(word[15:4]) > 1);
      hold_n = ok_n ? word[15:4] : 12'h000;
    end
    @(posedge clk);
    exp_hold = hold_n; exp_act = act_n; exp_ok = ok_n;
    @(negedge clk);
    wr_stb = 0; exec_stb = 0;
    check(tag, "hold_cmd", hold_cmd, exp_hold);
    check(tag, "act_cmd", act_cmd, exp_act);
    check(tag, "wr_ok", {11'd0, wr_ok}, {11'd0, exp_ok});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5EED_0C4C));
    rst_n = 0; wr_stb = 0; exec_stb = 0; single_mode = 0; wr_word = '0;
    exp_hold = '0; exp_act = '0; exp_ok = 0;
    repeat (3) @(negedge clk);
    check("R9", "hold_cmd", hold_cmd, 12'h000);
    check("R9", "act_cmd", act_cmd, 12'h000);
    check("R9", "wr_ok", {11'd0, wr_ok}, 12'h000);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // directed corner cases
    step("R2", 1, 16'h0000, 0, 0);                   // all-zero word rejected
    step("R3", 1, make_valid(12'h000), 0, 0);        // valid all-idle message
    step("R3", 1, make_valid(12'hC00), 0, 0);        // ch1 charge
    step("R6", 0, 16'h0000, 1, 0);                   // execute it
    v = make_valid(12'h2A5) ^ 16'h0001;              // one bit off valid
    step("R4", 1, v, 0, 0);                          // rejected, act unchanged
    step("R5", 0, make_valid(12'h3FF), 0, 0);        // no strobe, no effect
    step("R6", 0, 16'h0000, 1, 0);                   // exec after failure -> idle
    step("R7", 1, make_valid(12'h041), 0, 1);        // two channels, single mode
    step("R7", 1, make_valid(12'h040), 0, 1);        // one channel, single mode
    step("R6", 0, 16'h0000, 1, 1);
    step("R8", 1, make_valid(12'h900), 0, 0);        // two channels accepted
    step("R8", 0, 16'h0000, 1, 1);                   // exec in single mode -> idle
    step("R10", 1, make_valid(12'h00C), 1, 0);       // act takes older 900
    step("R1", 1, make_valid(12'h003), 1, 0);        // ch6 charge, act gets 00C
    step("R1", 0, 16'h0000, 1, 0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] m;
      logic [15:0] w;
      logic        we, ee, se;
      m  = 12'($urandom);
      if ($urandom_range(0, 2) == 0) m = m & 12'h0C3;
      w  = make_valid(m);
      if ($urandom_range(0, 9) < 4) w = w ^ (16'h1 << $urandom_range(0, 15));
      we = ($urandom_range(0, 9) < 7);
      ee = ($urandom_range(0, 9) < 4);
      se = ($urandom_range(0, 9) < 3);
      step(we ? "R3/R4" : "R5/R6", we, w, ee, se);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule